// File: doc/BRIEF.md
# Attribute-Tagged SEC-DED Codec

This block protects a 64-bit data word with 8 check bits. The check bits also fold in a small attribute, such as a few block-address bits, that the array never stores. On a write, the caller gives the data and the attribute, and the block returns the check bits to be stored next to the data. On a read, the caller gives the stored data, the stored check bits and the attribute that this location should carry now.

The code uses odd-weight columns. The data bits need fewer columns than 8 check rows can supply, so each attribute bit gets one of the spare odd-weight columns. Because of this, a wrong attribute gives a syndrome that differs from any data or check-bit fault. The read side reports one of four outcomes:

- no error;
- a corrected single-bit error;
- an attribute mismatch;
- an unrecoverable error.

It also returns the corrected data and the position of the failing bit. Read inputs are captured on a strobe, and the result appears one cycle later. Array storage, scrubbing and retry are handled outside this block.

Top module: `atag_codec`

## Requirements
- R1: `encCheck` is the XOR of the columns of every set bit in `encData` and `encAttr`. The column table lists the 8-bit values with odd weight of at least 3 in ascending numeric order, counting from entry 0. Data bit i uses entry i. Attribute bit j uses entry 64+j. Check bit j uses the column with only bit j set.
- R2: When `rdValid` is high at a clock edge, `outValid` is high for exactly the following cycle, and the results for that read are shown then. With no strobe, `outValid` is low, and `status`, `corrData` and `errIndex` hold their values.
- R3: `status` is one-hot whenever `outValid` is high: bit 0 means no error, bit 1 corrected, bit 2 attribute mismatch, bit 3 unrecoverable.
- R4: A word whose check bits match its data and the current attribute gives status bit 0, `corrData` equal to the read data, and `errIndex` 0.
- R5: A word with one data bit i inverted gives status bit 1, the original data restored, and `errIndex` i.
- R6: A word with one stored check bit j inverted gives status bit 1, `corrData` equal to the read data, and `errIndex` 64+j.
- R7: A read whose attribute differs in exactly one bit j from the attribute used on the write gives status bit 2, `corrData` equal to the read data, and `errIndex` 72+j.
- R8: Any two inverted bits among the 72 stored bits give status bit 3, `corrData` equal to the read data, and `errIndex` 0.
- R9: An attribute that differs in two bits from the written one gives status bit 3 and `errIndex` 0.
- R10: An odd-weight syndrome that is not a column of a stored or attribute bit (table entries 68 and above) gives status bit 3 and leaves the data unchanged.
- R11: While `rstN` is low, and after reset until the first strobe, `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| encData | input | 64 | Data to be written |
| encAttr | input | 4 | Attribute for the write |
| encCheck | output | 8 | Check bits to store (combinational) |
| rdValid | input | 1 | Read strobe; captures the read inputs |
| rdData | input | 64 | Stored data read back |
| rdCheck | input | 8 | Stored check bits read back |
| rdAttr | input | 4 | Attribute expected at this location |
| outValid | output | 1 | Result valid, one cycle after the strobe |
| status | output | 4 | One-hot outcome |
| corrData | output | 64 | Data with any single data-bit error fixed |
| errIndex | output | 7 | Position of the failing bit |

## Verification
A wrong entry in the column table, or a mis-ordered comparison in the classifier, shows up as a wrong status or index on the very result that follows the strobe. Such a result can also flip the wrong data bit. Random clean words and single, double and attribute faults reach every column in the table. A stale capture register shows up one cycle after the strobe, as data belonging to an earlier read.

// File: rtl/atag_pkg.sv
package atag_pkg;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int ATTR_W = 4;
  localparam int NCOL   = DATA_W + ATTR_W;
  localparam int NPOS   = DATA_W + CHK_W + ATTR_W;
  localparam int IDX_W  = $clog2(NPOS);

  typedef logic [NCOL-1:0][CHK_W-1:0] colTable_t;

  typedef struct packed {
    logic capture;
  } ctrl_t;

  typedef enum logic [3:0] {
    ST_OK    = 4'b0001,
    ST_CORR  = 4'b0010,
    ST_ATTR  = 4'b0100,
    ST_UNREC = 4'b1000
  } status_e;

  // Odd-weight vectors of weight three or more, ascending numeric order.
  function automatic colTable_t buildCols();
    colTable_t tbl = '0;
    int n = 0;
    for (int v = 0; v < (1 << CHK_W); v++) begin
      logic [CHK_W-1:0] c;
      int w;
      c = CHK_W'(v);
      w = $countones(c);
      if ((w % 2 == 1) && (w >= 3) && (n < NCOL)) begin
        tbl[n] = c;
        n++;
      end
    end
    return tbl;
  endfunction

  localparam colTable_t COLS = buildCols();
endpackage

// File: rtl/atag_ctrl.sv
module atag_ctrl
  import atag_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  rdValid,
  output ctrl_t ctrl,
  output logic  outValid
);
  logic validQ;

  always_comb ctrl.capture = rdValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= rdValid;
  end

  assign outValid = validQ;
endmodule

// File: rtl/atag_datapath.sv
module atag_datapath
  import atag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] encData,
  input  logic [ATTR_W-1:0] encAttr,
  output logic [CHK_W-1:0]  encCheck,
  input  logic [DATA_W-1:0] rdData,
  input  logic [CHK_W-1:0]  rdCheck,
  input  logic [ATTR_W-1:0] rdAttr,
  output logic [3:0]        status,
  output logic [DATA_W-1:0] corrData,
  output logic [IDX_W-1:0]  errIndex
);
  logic [DATA_W-1:0] dataQ;
  logic [CHK_W-1:0]  chkQ;
  logic [ATTR_W-1:0] attrQ;
  logic [CHK_W-1:0]  syndrome;
  status_e           stNext;

  function automatic logic [CHK_W-1:0] genCheck(logic [DATA_W-1:0] d,
                                                logic [ATTR_W-1:0] a);
    logic [CHK_W-1:0] s = '0;
    for (int i = 0; i < DATA_W; i++)
      if (d[i]) s ^= COLS[i];
    for (int j = 0; j < ATTR_W; j++)
      if (a[j]) s ^= COLS[DATA_W+j];
    return s;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
      chkQ  <= '0;
      attrQ <= '0;
    end else if (ctrl.capture) begin
      dataQ <= rdData;
      chkQ  <= rdCheck;
      attrQ <= rdAttr;
    end
  end

  assign encCheck = genCheck(encData, encAttr);
  assign syndrome = chkQ ^ genCheck(dataQ, attrQ);

  always_comb begin
    stNext   = ST_UNREC;
    corrData = dataQ;
    errIndex = '0;
    if (syndrome == '0) begin
      stNext = ST_OK;
    end else if (^syndrome) begin
      for (int i = 0; i < DATA_W; i++) begin
        if (syndrome == COLS[i]) begin
          stNext      = ST_CORR;
          corrData[i] = ~dataQ[i];
          errIndex    = IDX_W'(i);
        end
      end
      for (int j = 0; j < CHK_W; j++) begin
        if (syndrome == (CHK_W'(1) << j)) begin
          stNext   = ST_CORR;
          errIndex = IDX_W'(DATA_W + j);
        end
      end
      for (int j = 0; j < ATTR_W; j++) begin
        if (syndrome == COLS[DATA_W+j]) begin
          stNext   = ST_ATTR;
          errIndex = IDX_W'(DATA_W + CHK_W + j);
        end
      end
    end
  end

  assign status = stNext;
endmodule

// File: rtl/atag_codec.sv
module atag_codec
  import atag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] encData,
  input  logic [ATTR_W-1:0] encAttr,
  output logic [CHK_W-1:0]  encCheck,
  input  logic              rdValid,
  input  logic [DATA_W-1:0] rdData,
  input  logic [CHK_W-1:0]  rdCheck,
  input  logic [ATTR_W-1:0] rdAttr,
  output logic              outValid,
  output logic [3:0]        status,
  output logic [DATA_W-1:0] corrData,
  output logic [IDX_W-1:0]  errIndex
);
  ctrl_t ctrl;

  atag_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rdValid  (rdValid),
    .ctrl     (ctrl),
    .outValid (outValid)
  );

  atag_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .encData  (encData),
    .encAttr  (encAttr),
    .encCheck (encCheck),
    .rdData   (rdData),
    .rdCheck  (rdCheck),
    .rdAttr   (rdAttr),
    .status   (status),
    .corrData (corrData),
    .errIndex (errIndex)
  );
endmodule

// File: rtl/atag_checker.sv
module atag_checker
  import atag_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              rdValid,
  input logic [DATA_W-1:0] rdData,
  input logic              outValid,
  input logic [3:0]        status,
  input logic [DATA_W-1:0] corrData,
  input logic [IDX_W-1:0]  errIndex
);
  p_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> outValid);

  p_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |=> !outValid);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |=> ($stable(corrData) && $stable(status) && $stable(errIndex)));

  p_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($countones(status) == 1));

  p_clean_pass_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && status == 4'b0001) |-> (corrData == $past(rdData) && errIndex == '0));

  p_single_fix_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && status == 4'b0010 && errIndex < IDX_W'(DATA_W))
      |-> ($countones(corrData ^ $past(rdData)) == 1));

  p_check_fix_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && status == 4'b0010 && errIndex >= IDX_W'(DATA_W))
      |-> (corrData == $past(rdData) && errIndex < IDX_W'(DATA_W + CHK_W)));

  p_attr_tag_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && status == 4'b0100)
      |-> (corrData == $past(rdData) && errIndex >= IDX_W'(DATA_W + CHK_W)));

  p_unrec_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && status == 4'b1000) |-> (corrData == $past(rdData) && errIndex == '0));
endmodule

bind atag_codec atag_checker u_chk (.*);

// File: tb/sim_atag_codec.sv
`timescale 1ns/1ps
module sim_atag_codec;
  logic        clk = 1'b0;
  logic        rstN;
  logic [63:0] encData;
  logic [3:0]  encAttr;
  logic [7:0]  encCheck;
  logic        rdValid;
  logic [63:0] rdData;
  logic [7:0]  rdCheck;
  logic [3:0]  rdAttr;
  logic        outValid;
  logic [3:0]  status;
  logic [63:0] corrData;
  logic [6:0]  errIndex;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  atag_codec u0 (.*);

  function automatic logic [7:0] refCol(int idx);
    int n = 0;
    for (int v = 1; v < 256; v++) begin
      logic [7:0] b = v[7:0];
      int w = $countones(b);
      if (w >= 3 && (w & 1) == 1) begin
        if (n == idx) return b;
        n++;
      end
    end
    return 8'h00;
  endfunction

  function automatic logic [7:0] refEnc(logic [63:0] d, logic [3:0] a);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 64; i++) if (d[i]) c = c ^ refCol(i);
    for (int j = 0; j < 4; j++)  if (a[j]) c = c ^ refCol(64 + j);
    return c;
  endfunction

  task automatic expectEq(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doRead(logic [63:0] d, logic [7:0] c, logic [3:0] a,
                        logic [3:0] expSt, logic [63:0] expD, logic [6:0] expI,
                        string tag);
    @(negedge clk);
    rdData = d; rdCheck = c; rdAttr = a; rdValid = 1'b1;
    @(negedge clk);
    rdValid = 1'b0;
    rdData  = ~d;
    expectEq({tag, " R2 outValid"}, 64'(outValid), 64'd1);
    expectEq({tag, " R3 status"}, 64'(status), 64'(expSt));
    expectEq({tag, " data"}, corrData, expD);
    expectEq({tag, " index"}, 64'(errIndex), 64'(expI));
  endtask

  task automatic flipPos(inout logic [63:0] d, inout logic [7:0] c, input int p);
    if (p < 64) d[p] = ~d[p];
    else        c[p-64] = ~c[p-64];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [63:0] d, dx;
    logic [7:0]  c, cx;
    logic [3:0]  a, ax;
    void'($urandom(32'd20240611));
    rstN = 1'b0; rdValid = 1'b0; rdData = '0; rdCheck = '0; rdAttr = '0;
    encData = '0; encAttr = '0;
    repeat (3) @(negedge clk);
    expectEq("R11 outValid in reset", 64'(outValid), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    expectEq("R11 outValid after reset", 64'(outValid), 64'd0);

    // R1: encoder against bench model
    for (int t = 0; t < 40; t++) begin
      encData = {$urandom, $urandom};
      encAttr = 4'($urandom);
      if (t == 0) begin encData = '0; encAttr = '0; end
      if (t == 1) begin encData = '1; encAttr = '1; end
      #1;
      expectEq("R1 encCheck", 64'(encCheck), 64'(refEnc(encData, encAttr)));
      @(negedge clk);
    end

    // Directed corners
    d = 64'h0; a = 4'h0; c = refEnc(d, a);
    doRead(d, c, a, 4'b0001, d, 7'd0, "R4 zero clean");
    d = '1; a = 4'hF; c = refEnc(d, a);
    doRead(d, c, a, 4'b0001, d, 7'd0, "R4 ones clean");
    d = 64'hDEAD_BEEF_0123_4567; a = 4'h5; c = refEnc(d, a);
    dx = d; dx[0] = ~dx[0];
    doRead(dx, c, a, 4'b0010, d, 7'd0, "R5 bit0");
    dx = d; dx[63] = ~dx[63];
    doRead(dx, c, a, 4'b0010, d, 7'd63, "R5 bit63");
    cx = c; cx[7] = ~cx[7];
    doRead(d, cx, a, 4'b0010, d, 7'd71, "R6 check7");
    doRead(d, c, a ^ 4'h8, 4'b0100, d, 7'd75, "R7 attr3");
    dx = d; cx = c; dx[63] = ~dx[63]; cx[0] = ~cx[0];
    doRead(dx, cx, a, 4'b1000, dx, 7'd0, "R8 pos63+64");
    doRead(d, c, a ^ 4'h3, 4'b1000, d, 7'd0, "R9 attr pair");
    doRead(d, c ^ refCol(68), a, 4'b1000, d, 7'd0, "R10 entry68");
    doRead(d, c ^ 8'hFE, a, 4'b1000, d, 7'd0, "R10 weight7");
    // R2: hold with no strobe
    @(negedge clk);
    expectEq("R2 outValid idle", 64'(outValid), 64'd0);
    expectEq("R2 data held", corrData, d);

    // Random mix
    for (int t = 0; t < 600; t++) begin
      int kind = int'($urandom % 6);
      d = {$urandom, $urandom};
      a = 4'($urandom);
      c = refEnc(d, a);
      dx = d; cx = c; ax = a;
      case (kind)
        0: doRead(d, c, a, 4'b0001, d, 7'd0, "R4 rand");
        1: begin
          int p = int'($urandom % 72);
          flipPos(dx, cx, p);
          doRead(dx, cx, a, 4'b0010, d, 7'(p), p < 64 ? "R5 rand" : "R6 rand");
        end
        2: begin
          int j = int'($urandom % 4);
          ax[j] = ~ax[j];
          doRead(d, c, ax, 4'b0100, d, 7'(72 + j), "R7 rand");
        end
        3: begin
          int p1 = int'($urandom % 72);
          int p2 = (p1 + 1 + int'($urandom % 71)) % 72;
          flipPos(dx, cx, p1);
          flipPos(dx, cx, p2);
          doRead(dx, cx, a, 4'b1000, dx, 7'd0, "R8 rand");
        end
        4: begin
          int j1 = int'($urandom % 4);
          int j2 = (j1 + 1 + int'($urandom % 3)) % 4;
          ax[j1] = ~ax[j1];
          ax[j2] = ~ax[j2];
          doRead(d, c, ax, 4'b1000, d, 7'd0, "R9 rand");
        end
        default: begin
          int e = 68 + int'($urandom % 52);
          doRead(d, c ^ refCol(e), a, 4'b1000, d, 7'd0, "R10 rand");
        end
      endcase
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule